// File: doc/BRIEF.md
# Two-phase CCD clock sequencer

This block generates every clock that a full-frame CCD needs during one exposure-and-readout cycle. The parallel (vertical) register and the serial (horizontal) register each get a pair of complementary phases. A transfer-gate output is tied to vertical phase 2, a summing-gate output is tied to horizontal phase 2, and a reset gate pulses once for each pixel. Every pulse width is a count of system-clock cycles set by a parameter. For the default 50 MHz clock the defaults give 18 µs vertical pulses, a pixel rate of about 98 kHz, a 500 ns reset pulse and a vertical-to-horizontal gap of at least 6 µs. The row and column counts are parameters, so the same code serves the 128-row and the 256-row sensor.

A start pulse begins a frame, and the scan mode is captured at that moment. The first stage is integration, which lasts a fixed number of cycles. During integration the shutter-request output is high and no clocks move. In line-binning mode the vertical register is then shifted once for every row with no horizontal activity, and one serial readout of all columns follows. In area-scan mode each row gets one vertical shift followed by a full serial readout. After each reset-gate pulse a one-cycle pixel strobe tells an external converter when to sample. A one-cycle done flag closes the frame.

Top module: `ccd_seq_top`

## Requirements
- R1: While reset is held, and at all times when neither busy nor done is high, the outputs rest at p1v=1, p2v=0, tg=0, p1h=0, p2h=1, sg=1, rg=0, pix_valid=0 and shutter=0.
- R2: tg equals p2v and sg equals p2h in every cycle.
- R3: Neither phase pair is ever low in both phases at once. Each p2v high pulse lasts exactly VW_CYC+2*OVL_CYC cycles, each p1v low interval lasts exactly VW_CYC cycles, and each p1h high pulse lasts exactly HW_CYC+2*OVL_CYC cycles.
- R4: A start pulse while idle raises busy on the next cycle. Shutter is then high for exactly INT_CYC cycles, and no clock moves while shutter is high.
- R5: With mode=0 (line binning), p2v pulses exactly ROWS times before the first p1h pulse, and exactly COLS p1h pulses follow.
- R6: With mode=1 (area scan), there are ROWS p2v pulses, and each one is followed by exactly COLS p1h pulses before the next p2v pulse or the end of the frame.
- R7: At least GAP_CYC cycles separate each falling edge of p2v from the next rising edge of p1h.
- R8: rg gives one pulse per pixel, RG_W cycles wide, and only while p1h is high and p2h is low.
- R9: pix_valid is a one-cycle pulse exactly PV_DLY cycles after each falling edge of rg.
- R10: done pulses for exactly one cycle after the last pixel. busy is low while done is high and after it.
- R11: start and mode have no effect while busy is high. The running frame completes unchanged, with a single done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Frame start pulse, accepted only while idle |
| mode | input | 1 | 0 = line binning, 1 = area scan, captured with start |
| p1v | output | 1 | Vertical phase 1 |
| p2v | output | 1 | Vertical phase 2 |
| tg | output | 1 | Transfer gate, same as p2v |
| p1h | output | 1 | Horizontal phase 1 |
| p2h | output | 1 | Horizontal phase 2 |
| sg | output | 1 | Summing gate, same as p2h |
| rg | output | 1 | Reset gate, one pulse per pixel |
| pix_valid | output | 1 | Converter sample strobe |
| shutter | output | 1 | High while the shutter must be open (integration) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench drives complete frames in both modes on a small array and counts every edge of every clock. A binning sequencer that leaked serial clocks into the vertical phase would show early p1h pulses. An area-scan sequencer that lost track of the column count would give the wrong number of pixels in at least one row. Each pulse width, the gap after the last vertical shift, and the delay from the reset gate to the strobe are measured against the parameters. An off-by-one in any segment counter therefore changes a measured length. A second start pulse with the opposite mode is sent in the middle of a frame. If the design restarted or switched mode, the pulse counts would differ or a second done pulse would appear.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic {
    SCAN_BIN  = 1'b0,
    SCAN_AREA = 1'b1
  } scan_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_INTEG,
    SQ_VSHIFT,
    SQ_GAP,
    SQ_HREAD,
    SQ_DONE
  } seq_state_e;

  // segments of one two-phase transfer: overlap, move phase, overlap, rest phase
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_OV1,
    PS_MOVE,
    PS_OV2,
    PS_REST
  } pair_seg_e;

endpackage

// File: rtl/ccd_phase_pair.sv
module ccd_phase_pair
  import ccd_seq_pkg::*;
#(
  parameter int unsigned OVL_CYC  = 5,
  parameter int unsigned MOVE_CYC = 900,
  parameter int unsigned REST_CYC = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic rest_ph,
  output logic move_ph,
  output logic idle,
  output logic fin
);

  localparam int unsigned LMAX0 = (MOVE_CYC > REST_CYC) ? MOVE_CYC : REST_CYC;
  localparam int unsigned LMAX  = (LMAX0 > OVL_CYC) ? LMAX0 : OVL_CYC;
  localparam int unsigned CW    = $clog2(LMAX + 1);

  pair_seg_e     seg_q, seg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    seg_d = seg_q;
    cnt_d = cnt_q;
    fin   = 1'b0;
    unique case (seg_q)
      PS_IDLE: begin
        if (go) begin
          seg_d = PS_OV1;
          cnt_d = CW'(OVL_CYC - 1);
        end
      end
      PS_OV1: begin
        if (cnt_zero) begin
          seg_d = PS_MOVE;
          cnt_d = CW'(MOVE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PS_MOVE: begin
        if (cnt_zero) begin
          seg_d = PS_OV2;
          cnt_d = CW'(OVL_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PS_OV2: begin
        if (cnt_zero) begin
          seg_d = PS_REST;
          cnt_d = CW'(REST_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PS_REST: begin
        if (cnt_zero) begin
          seg_d = PS_IDLE;
          fin   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: seg_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= PS_IDLE;
      cnt_q <= '0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  // move phase high from first overlap through second overlap; rest phase low only in move segment
  assign move_ph = (seg_q == PS_OV1) || (seg_q == PS_MOVE) || (seg_q == PS_OV2);
  assign rest_ph = (seg_q != PS_MOVE);
  assign idle    = (seg_q == PS_IDLE);

endmodule

// File: rtl/ccd_pix_strobe.sv
module ccd_pix_strobe #(
  parameter int unsigned RG_W   = 25,
  parameter int unsigned PV_DLY = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic p2h,
  output logic rg,
  output logic pix_valid
);

  localparam int unsigned RCW = $clog2(RG_W + 1);
  localparam int unsigned PCW = $clog2(PV_DLY + 2);

  logic           p2h_q;
  logic           p2h_fall;
  logic [RCW-1:0] rg_cnt_q, rg_cnt_d;
  logic [PCW-1:0] pv_cnt_q, pv_cnt_d;
  logic           rg_last;

  assign p2h_fall = p2h_q && !p2h;
  assign rg_last  = (rg_cnt_q == RCW'(1));

  always_comb begin
    rg_cnt_d = rg_cnt_q;
    if (p2h_fall) begin
      rg_cnt_d = RCW'(RG_W);
    end else if (rg_cnt_q != '0) begin
      rg_cnt_d = rg_cnt_q - 1'b1;
    end
  end

  always_comb begin
    pv_cnt_d = pv_cnt_q;
    if (rg_last) begin
      pv_cnt_d = PCW'(PV_DLY + 1);
    end else if (pv_cnt_q != '0) begin
      pv_cnt_d = pv_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p2h_q    <= 1'b1;
      rg_cnt_q <= '0;
      pv_cnt_q <= '0;
    end else begin
      p2h_q    <= p2h;
      rg_cnt_q <= rg_cnt_d;
      pv_cnt_q <= pv_cnt_d;
    end
  end

  assign rg        = (rg_cnt_q != '0);
  assign pix_valid = (pv_cnt_q == PCW'(1));

endmodule

// File: rtl/ccd_seq_ctrl.sv
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int unsigned ROWS    = 128,
  parameter int unsigned COLS    = 1044,
  parameter int unsigned INT_CYC = 50000,
  parameter int unsigned GAP_CYC = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  scan_mode_e mode,
  input  logic       v_idle,
  input  logic       v_fin,
  input  logic       h_idle,
  input  logic       h_fin,
  output logic       v_go,
  output logic       h_go,
  output logic       shutter,
  output logic       busy,
  output logic       done
);

  localparam int unsigned RW   = $clog2(ROWS + 1);
  localparam int unsigned CW   = $clog2(COLS + 1);
  localparam int unsigned TMAX = (INT_CYC > GAP_CYC) ? INT_CYC : GAP_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [RW-1:0] ROW_ALL  = RW'(ROWS);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);

  seq_state_e    st_q, st_d;
  scan_mode_e    mode_q, mode_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_zero;

  assign tmr_zero = (tmr_q == '0);

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    row_d  = row_q;
    col_d  = col_q;
    tmr_d  = tmr_q;
    v_go   = 1'b0;
    h_go   = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d   = SQ_INTEG;
          mode_d = mode;
          row_d  = '0;
          col_d  = '0;
          tmr_d  = TW'(INT_CYC - 1);
        end
      end
      SQ_INTEG: begin
        if (tmr_zero) st_d = SQ_VSHIFT;
        else          tmr_d = tmr_q - 1'b1;
      end
      SQ_VSHIFT: begin
        v_go = v_idle;
        if (v_fin) begin
          row_d = row_q + 1'b1;
          if ((mode_q == SCAN_AREA) || (row_q == ROW_LAST)) begin
            st_d  = SQ_GAP;
            tmr_d = TW'(GAP_CYC - 1);
          end
        end
      end
      SQ_GAP: begin
        if (tmr_zero) begin
          st_d  = SQ_HREAD;
          col_d = '0;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      SQ_HREAD: begin
        h_go = h_idle;
        if (h_fin) begin
          if (col_q == COL_LAST) begin
            col_d = '0;
            st_d  = (row_q == ROW_ALL) ? SQ_DONE : SQ_VSHIFT;
          end else begin
            col_d = col_q + 1'b1;
          end
        end
      end
      SQ_DONE: st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      mode_q <= SCAN_BIN;
      row_q  <= '0;
      col_q  <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      row_q  <= row_d;
      col_q  <= col_d;
      tmr_q  <= tmr_d;
    end
  end

  assign shutter = (st_q == SQ_INTEG);
  assign busy    = (st_q != SQ_IDLE) && (st_q != SQ_DONE);
  assign done    = (st_q == SQ_DONE);

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top
  import ccd_seq_pkg::*;
#(
  parameter int unsigned ROWS    = 128,
  parameter int unsigned COLS    = 1044,
  parameter int unsigned INT_CYC = 50000,
  parameter int unsigned VW_CYC  = 900,
  parameter int unsigned OVL_CYC = 5,
  parameter int unsigned HW_CYC  = 250,
  parameter int unsigned RG_W    = 25,
  parameter int unsigned GAP_CYC = 300,
  parameter int unsigned PV_DLY  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode,
  output logic p1v,
  output logic p2v,
  output logic tg,
  output logic p1h,
  output logic p2h,
  output logic sg,
  output logic rg,
  output logic pix_valid,
  output logic shutter,
  output logic busy,
  output logic done
);

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  logic v_go, v_idle, v_fin, p2v_i;
  logic h_go, h_idle, h_fin, p2h_i;

  ccd_seq_ctrl #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .INT_CYC(INT_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (srst_n),
    .start  (start),
    .mode   (scan_mode_e'(mode)),
    .v_idle (v_idle),
    .v_fin  (v_fin),
    .h_idle (h_idle),
    .h_fin  (h_fin),
    .v_go   (v_go),
    .h_go   (h_go),
    .shutter(shutter),
    .busy   (busy),
    .done   (done)
  );

  // vertical pair: phase 1 rests high, phase 2 moves the charge one row
  ccd_phase_pair #(
    .OVL_CYC (OVL_CYC),
    .MOVE_CYC(VW_CYC),
    .REST_CYC(VW_CYC)
  ) u_vpair (
    .clk    (clk),
    .rst_n  (srst_n),
    .go     (v_go),
    .rest_ph(p1v),
    .move_ph(p2v_i),
    .idle   (v_idle),
    .fin    (v_fin)
  );

  // horizontal pair: phase 2 rests high, phase 1 moves one pixel
  ccd_phase_pair #(
    .OVL_CYC (OVL_CYC),
    .MOVE_CYC(HW_CYC),
    .REST_CYC(HW_CYC)
  ) u_hpair (
    .clk    (clk),
    .rst_n  (srst_n),
    .go     (h_go),
    .rest_ph(p2h_i),
    .move_ph(p1h),
    .idle   (h_idle),
    .fin    (h_fin)
  );

  ccd_pix_strobe #(
    .RG_W  (RG_W),
    .PV_DLY(PV_DLY)
  ) u_strobe (
    .clk      (clk),
    .rst_n    (srst_n),
    .p2h      (p2h_i),
    .rg       (rg),
    .pix_valid(pix_valid)
  );

  assign p2v = p2v_i;
  assign tg  = p2v_i;
  assign p2h = p2h_i;
  assign sg  = p2h_i;

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk #(
  parameter int unsigned GAP_CYC = 300
) (
  input logic clk,
  input logic rst_n,
  input logic p1v,
  input logic p2v,
  input logic p1h,
  input logic p2h,
  input logic rg,
  input logic pix_valid,
  input logic shutter,
  input logic busy,
  input logic done
);

  logic [15:0] gap_q;
  logic        p2v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      p2v_q <= 1'b0;
    end else begin
      p2v_q <= p2v;
      if (p2v_q && !p2v)  gap_q <= 16'd1;
      else if (gap_q != '1) gap_q <= gap_q + 16'd1;
    end
  end

  AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> (p1v && !p2v && !p1h && p2h && !rg && !shutter)); // R1
  AST_V_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (p1v || p2v)); // R3
  AST_H_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (p1h || p2h)); // R3
  AST_SHUTTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    shutter |-> (p1v && !p2v && !p1h && !rg)); // R4
  AST_VH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p1h) |-> (gap_q >= 16'(GAP_CYC))); // R7
  AST_RG_IN_P1H: assert property (@(posedge clk) disable iff (!rst_n)
    rg |-> (p1h && !p2h)); // R8
  AST_PV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10

endmodule

bind ccd_seq_top ccd_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .p1v      (p1v),
  .p2v      (p2v),
  .p1h      (p1h),
  .p2h      (p2h),
  .rg       (rg),
  .pix_valid(pix_valid),
  .shutter  (shutter),
  .busy     (busy),
  .done     (done)
);

// File: tb/ccd_seq_top_tb.sv
module ccd_seq_top_tb;

  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int INTC = 20;
  localparam int VW   = 5;
  localparam int OVL  = 1;
  localparam int HW   = 4;
  localparam int RGW  = 2;
  localparam int GAP  = 7;
  localparam int PVD  = 3;

  logic clk = 1'b0;
  logic rst_n, start, mode;
  logic p1v, p2v, tg, p1h, p2h, sg, rg, pix_valid, shutter, busy, done;

  ccd_seq_top #(
    .ROWS(ROWS), .COLS(COLS), .INT_CYC(INTC), .VW_CYC(VW), .OVL_CYC(OVL),
    .HW_CYC(HW), .RG_W(RGW), .GAP_CYC(GAP), .PV_DLY(PVD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .p1v(p1v), .p2v(p2v), .tg(tg), .p1h(p1h), .p2h(p2h), .sg(sg), .rg(rg),
    .pix_valid(pix_valid), .shutter(shutter), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int cyc = 0;

  // monitor state
  logic p_p2v = 0, p_p1v = 1, p_p1h = 0, p_rg = 0, p_pv = 0, p_done = 0;
  int len_p2v = 0, len_p1vl = 0, len_p1h = 0, len_rg = 0;
  int gcnt = 0, rg_fall_cyc = -100;
  bit gap_pend = 0;
  int r2_bad = 0, r3_bad = 0;
  // per-frame counters
  bit f_mode = 0;
  int f_v, f_h, f_hrow, f_rowbad, f_hearly, f_wbad, f_gapbad;
  int f_rg, f_rgbad, f_pv, f_pvbad, f_done, f_donebad, f_shut, f_shutbad;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic clr_frame();
    f_v = 0; f_h = 0; f_hrow = 0; f_rowbad = 0; f_hearly = 0; f_wbad = 0; f_gapbad = 0;
    f_rg = 0; f_rgbad = 0; f_pv = 0; f_pvbad = 0; f_done = 0; f_donebad = 0;
    f_shut = 0; f_shutbad = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    gcnt++;
    if (rst_n) begin
      if (tg !== p2v || sg !== p2h) r2_bad++;
      if ((!p1v && !p2v) || (!p1h && !p2h)) r3_bad++;
      if (p2v) len_p2v++;
      if (!p2v && p_p2v) begin
        if (len_p2v != VW + 2*OVL) f_wbad++;
        len_p2v = 0; gcnt = 0; gap_pend = 1;
      end
      if (p2v && !p_p2v) begin
        if (f_mode && f_v > 0 && f_hrow != COLS) f_rowbad++;
        f_hrow = 0; f_v++;
      end
      if (!p1v) len_p1vl++;
      if (p1v && !p_p1v) begin
        if (len_p1vl != VW) f_wbad++;
        len_p1vl = 0;
      end
      if (p1h) len_p1h++;
      if (p1h && !p_p1h) begin
        f_h++; f_hrow++;
        if (!f_mode && f_v < ROWS) f_hearly++;
        if (gap_pend) begin
          if (gcnt < GAP) f_gapbad++;
          gap_pend = 0;
        end
      end
      if (!p1h && p_p1h) begin
        if (len_p1h != HW + 2*OVL) f_wbad++;
        len_p1h = 0;
      end
      if (rg) len_rg++;
      if (rg && !p_rg) f_rg++;
      if (!rg && p_rg) begin
        if (len_rg != RGW) f_rgbad++;
        len_rg = 0; rg_fall_cyc = cyc;
      end
      if (pix_valid) begin
        f_pv++;
        if (cyc - rg_fall_cyc != PVD || p_pv) f_pvbad++;
      end
      if (done) begin
        f_done++;
        if (busy || p_done) f_donebad++;
      end
      if (shutter) begin
        f_shut++;
        if (p2v || p1h || rg || !p1v) f_shutbad++;
      end
    end
    p_p2v = p2v; p_p1v = p1v; p_p1h = p1h; p_rg = rg; p_pv = pix_valid; p_done = done;
  end

  task automatic run_frame(input bit m, input bit disturb);
    string tagm;
    int t;
    tagm = m ? "R6" : "R5";
    @(negedge clk);
    clr_frame();
    f_mode = m;
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && shutter === 1'b1, "R4 busy and shutter after start", {busy, shutter}, 3);
    if (disturb) begin
      repeat (40) @(negedge clk);
      start = 1'b1; mode = ~m;
      @(negedge clk);
      start = 1'b0; mode = m;
    end
    t = 0;
    while (done !== 1'b1 && t < 8000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 8000, "R10 frame reached done", t, 8000);
    repeat (30) @(negedge clk);
    chk(f_shut == INTC, "R4 shutter cycles", f_shut, INTC);
    chk(f_shutbad == 0, "R4 no clocks while shutter", f_shutbad, 0);
    chk(f_v == ROWS, {tagm, " vertical pulse count"}, f_v, ROWS);
    chk(f_h == (m ? ROWS*COLS : COLS), {tagm, " horizontal pulse count"}, f_h, m ? ROWS*COLS : COLS);
    if (!m) chk(f_hearly == 0, "R5 no horizontal before last vertical", f_hearly, 0);
    else    chk(f_rowbad == 0 && f_hrow == COLS, "R6 pixels per row", f_hrow, COLS);
    chk(f_wbad == 0, "R3 pulse widths", f_wbad, 0);
    chk(f_gapbad == 0, "R7 vertical to horizontal gap", f_gapbad, 0);
    chk(f_rg == f_h && f_rgbad == 0, "R8 reset gate per pixel", f_rg, f_h);
    chk(f_pv == f_h && f_pvbad == 0, "R9 strobe count and delay", f_pv, f_h);
    chk(f_done == 1 && f_donebad == 0, "R10 single done", f_done, 1);
    chk(busy === 1'b0, "R10 busy low after done", busy, 0);
    chk(p1v === 1 && p2v === 0 && p1h === 0 && p2h === 1 && rg === 0,
        "R1 idle pattern after frame", {p1v, p2v, p1h, p2h, rg}, 5'b10010);
    if (disturb) chk(f_v == ROWS && f_done == 1, "R11 restart ignored", f_v, ROWS);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(p1v === 1 && p2v === 0 && tg === 0 && p1h === 0 && p2h === 1 && sg === 1,
        "R1 reset clock levels", {p1v, p2v, tg, p1h, p2h, sg}, 6'b100011);
    chk(rg === 0 && pix_valid === 0 && shutter === 0 && busy === 0 && done === 0,
        "R1 reset flags", {rg, pix_valid, shutter, busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_frame(1'b0, 1'b0);
    run_frame(1'b1, 1'b0);
    run_frame(1'b0, 1'b1);
    run_frame(1'b1, 1'b1);
    chk(r2_bad == 0, "R2 gate outputs follow phase 2", r2_bad, 0);
    chk(r3_bad == 0, "R3 phases never both low", r3_bad, 0);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
      summary();
    end
  end

endmodule